// File: doc/BRIEF.md
# Stepwise Byte-Slice Multiplier

This block is an unsigned integer multiplier that software walks through one command at a time. A start command captures a multiplicand and a multiplier and clears a 64-bit accumulator. Each step command then folds in one 8-bit slice of the multiplier: the multiplicand times that slice, shifted to the slice's weight, is added to the accumulator. Fetch commands read the finished product back, either its low word or its high word.

When both operands fit in 16 bits the block runs in narrow mode, and two step commands finish the product. Otherwise it runs in wide mode, and four step commands are needed. The sequence must be followed in order. Any command that breaks it is dropped and raises a sticky error flag. A dropped command leaves the operands, the accumulator and the step count as they were.

A fetch names a destination index. The response echoes that index with the data, so the issuer can route the result. The high word is optional. In narrow mode it is always zero.

Top module: `stepmul_core`

## Requirements
- R1: After a synchronous active-low reset, `err_flag` and `rsp_valid` are 0 and no sequence is open, so a step or a fetch issued next is rejected.
- R2: A start command (`cmd_op`=0 with `cmd_step`=0) captures `cmd_opa` as the multiplicand and `cmd_opb` as the multiplier, clears the accumulator and the step count, and clears `err_flag`. It selects narrow mode (2 steps) when both operands are below 2^16, and wide mode (4 steps) otherwise.
- R3: A start command whose `cmd_step` is not 0 is rejected. It sets `err_flag` and leaves the open sequence (operands, accumulator, step count) untouched.
- R4: A step command (`cmd_op`=1) with index n in `cmd_step` is accepted only when n equals the completed step count plus one and n does not exceed the mode's step count. It adds multiplicand × multiplier bits [8n-1:8n-8], shifted left by 8(n-1), to the accumulator.
- R5: A step whose index is 0, out of order, beyond the mode's count, or issued with no open sequence sets `err_flag` and leaves the accumulator unchanged.
- R6: A low fetch (`cmd_op`=2), issued once all steps of the mode are done, produces on the next cycle `rsp_valid`=1, `rsp_data` = product bits [31:0], and `rsp_dst` = the command's `cmd_dst`.
- R7: A high fetch (`cmd_op`=3), issued once all steps are done, returns product bits [63:32]. This is zero in narrow mode.
- R8: A fetch issued before all steps of the mode are done, or with no open sequence, sets `err_flag` and produces no response.
- R9: `err_flag` stays set until the next accepted start. Fetches may be repeated, in either order, until the next start.
- R10: Responses and the error flag change exactly one clock after the command. `rsp_valid` is 0 in every cycle that follows a cycle without an accepted fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 start, 1 step, 2 low fetch, 3 high fetch |
| cmd_step | input | STEP_W (3) | Step index 1..4; must be 0 on start |
| cmd_dst | input | DST_W (5) | Destination index for a fetch |
| cmd_opa | input | DATA_W (32) | Multiplicand on start |
| cmd_opb | input | DATA_W (32) | Multiplier on start |
| rsp_valid | output | 1 | Fetch result present |
| rsp_dst | output | DST_W (5) | Destination index echoed from the fetch |
| rsp_data | output | DATA_W (32) | Low or high product word |
| err_flag | output | 1 | Sticky illegal-sequence flag |

## Verification
The hardest case to reach is a rejected command in the middle of a partly built product. Examples are a start that carries a step index, or an early fetch after two of four wide steps. A broken design can hide such a corruption, because the final product still looks plausible. The stimulus therefore opens a wide sequence and injects the illegal command between accepted steps. It then finishes the remaining steps and fetches both words. The damage to the operands or the accumulator shows up in the product value. A tail of fully random commands then hits the remaining orderings against the behavioural model on every clock.

// File: rtl/stepmul_pkg.sv
// Shared command encoding for the stepwise multiplier.
package stepmul_pkg;
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_LOW   = 2'd2,
        CMD_HIGH  = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/stepmul_seq.sv
// Sequence controller: checks command ordering, tracks mode and step count,
// and issues one-cycle enables to the datapath and response stage.
// Assumes a step index of 0 means "none" and that steps are numbered from 1.
module stepmul_seq
    import stepmul_pkg::*;
#(
    parameter int STEPS_WIDE = 4,
    parameter int STEP_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_op_e           cmd_op,
    input  logic [STEP_W-1:0] cmd_step,
    input  logic              wide_req,
    output logic              load_o,
    output logic              step_en_o,
    output logic [STEP_W-1:0] step_idx_o,
    output logic              fetch_lo_o,
    output logic              fetch_hi_o,
    output logic              err_o,
    output logic              wide_o
);
    localparam int STEPS_NARROW = STEPS_WIDE / 2;

    logic              active_q;
    logic              wide_q;
    logic [STEP_W-1:0] done_q;
    logic [STEP_W-1:0] need;
    logic              all_done;
    logic              start_ok;
    logic              step_ok;

    // Decode legality of the presented command against current state.
    always_comb begin
        need       = wide_q ? STEP_W'(STEPS_WIDE) : STEP_W'(STEPS_NARROW);
        all_done   = active_q && (done_q == need);
        start_ok   = cmd_valid && (cmd_op == CMD_START) && (cmd_step == '0);
        step_ok    = cmd_valid && (cmd_op == CMD_STEP) && active_q &&
                     (cmd_step == STEP_W'(done_q + 1'b1)) && (cmd_step <= need);
        fetch_lo_o = cmd_valid && (cmd_op == CMD_LOW) && all_done;
        fetch_hi_o = cmd_valid && (cmd_op == CMD_HIGH) && all_done;
        err_o      = cmd_valid && !(start_ok || step_ok || fetch_lo_o || fetch_hi_o);
        load_o     = start_ok;
        step_en_o  = step_ok;
        step_idx_o = cmd_step;
        wide_o     = wide_q;
    end

    // Sequence state: open flag, mode and completed step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            wide_q   <= 1'b0;
            done_q   <= '0;
        end else if (start_ok) begin
            active_q <= 1'b1;
            wide_q   <= wide_req;
            done_q   <= '0;
        end else if (step_ok) begin
            done_q   <= done_q + 1'b1;
        end
    end

    // Step count never runs past the mode's total (R4).
    assert_done_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q <= need);

    // An accepted step advances the count by exactly one (R4).
    assert_step_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en_o |=> done_q == $past(done_q) + 1'b1);
endmodule

// File: rtl/stepmul_acc.sv
// Operand registers and 64-bit accumulator. Each step adds the multiplicand
// times one multiplier slice at that slice's weight.
// Assumes the controller raises at most one of load/step per cycle.
module stepmul_acc #(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8,
    parameter int STEP_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                step_en,
    input  logic [STEP_W-1:0]   step_idx,
    output logic [2*DATA_W-1:0] acc_o
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int SLICES = DATA_W / SLICE_W;
    localparam int PP_W   = DATA_W + SLICE_W;

    logic [DATA_W-1:0] mcand_q;
    logic [DATA_W-1:0] mplier_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  addend [SLICES];
    logic [ACC_W-1:0]  sel_add;

    // One weighted partial product per multiplier slice.
    for (genvar g = 0; g < SLICES; g++) begin : g_pp
        logic [PP_W-1:0] pp;
        assign pp        = PP_W'(mcand_q) * PP_W'(mplier_q[g*SLICE_W +: SLICE_W]);
        assign addend[g] = ACC_W'(pp) << (g * SLICE_W);
    end

    // Pick the partial product named by the step index.
    always_comb begin
        sel_add = '0;
        for (int i = 0; i < SLICES; i++) begin
            if (step_idx == STEP_W'(i + 1)) sel_add = addend[i];
        end
    end

    // Operand capture and accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            mcand_q  <= opa;
            mplier_q <= opb;
            acc_q    <= '0;
        end else if (step_en) begin
            acc_q    <= acc_q + sel_add;
        end
    end

    assign acc_o = acc_q;

    // A legal step never wraps the accumulator (R4).
    assert_acc_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/stepmul_resp.sv
// Response register and sticky error flag.
// Assumes the fetch enables are mutually exclusive and never coincide with an error.
module stepmul_resp #(
    parameter int DATA_W = 32,
    parameter int DST_W  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_lo,
    input  logic                fetch_hi,
    input  logic                err_set,
    input  logic                err_clr,
    input  logic [2*DATA_W-1:0] acc,
    input  logic [DST_W-1:0]    dst,
    output logic                rsp_valid,
    output logic [DST_W-1:0]    rsp_dst,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                err_flag
);
    // Register the selected product word with its destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_dst   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fetch_lo || fetch_hi;
            if (fetch_lo || fetch_hi) begin
                rsp_dst  <= dst;
                rsp_data <= fetch_hi ? acc[2*DATA_W-1:DATA_W] : acc[DATA_W-1:0];
            end
        end
    end

    // Sticky error: set by any rejected command, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (err_set) err_flag <= 1'b1;
        else if (err_clr) err_flag <= 1'b0;
    end

    // Error stays up until a clearing start (R9).
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: rtl/stepmul_core.sv
// Top of the stepwise multiplier: decides narrow/wide mode from the operands
// and ties the sequence controller, accumulator and response stage together.
// Assumes one command per cycle at most and unsigned operands.
module stepmul_core
    import stepmul_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8,
    parameter int STEP_W  = 3,
    parameter int DST_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [STEP_W-1:0] cmd_step,
    input  logic [DST_W-1:0]  cmd_dst,
    input  logic [DATA_W-1:0] cmd_opa,
    input  logic [DATA_W-1:0] cmd_opb,
    output logic              rsp_valid,
    output logic [DST_W-1:0]  rsp_dst,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_flag
);
    localparam int HALF_W     = DATA_W / 2;
    localparam int STEPS_WIDE = DATA_W / SLICE_W;

    cmd_op_e               op;
    logic                  wide_req;
    logic                  load, step_en, fetch_lo, fetch_hi, err_pulse, wide;
    logic [STEP_W-1:0]     step_idx;
    logic [2*DATA_W-1:0]   acc;

    // Wide mode when either operand has a bit set above the low half.
    always_comb begin
        op       = cmd_op_e'(cmd_op);
        wide_req = (cmd_opa[DATA_W-1:HALF_W] != '0) || (cmd_opb[DATA_W-1:HALF_W] != '0);
    end

    stepmul_seq #(.STEPS_WIDE(STEPS_WIDE), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
        .cmd_step(cmd_step), .wide_req(wide_req), .load_o(load),
        .step_en_o(step_en), .step_idx_o(step_idx), .fetch_lo_o(fetch_lo),
        .fetch_hi_o(fetch_hi), .err_o(err_pulse), .wide_o(wide)
    );

    stepmul_acc #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .STEP_W(STEP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(load), .opa(cmd_opa), .opb(cmd_opb),
        .step_en(step_en), .step_idx(step_idx), .acc_o(acc)
    );

    stepmul_resp #(.DATA_W(DATA_W), .DST_W(DST_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .fetch_lo(fetch_lo), .fetch_hi(fetch_hi),
        .err_set(err_pulse), .err_clr(load), .acc(acc), .dst(cmd_dst),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_data(rsp_data),
        .err_flag(err_flag)
    );

    // Start carrying a step index is flagged and produces no response (R3).
    assert_bad_start_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == CMD_START && cmd_step != '0) |=> (err_flag && !rsp_valid));

    // Rejected fetch sets the error and returns nothing (R8).
    assert_early_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == CMD_LOW || op == CMD_HIGH) && !fetch_lo && !fetch_hi)
        |=> (err_flag && !rsp_valid));

    // High word of a narrow product is zero (R7).
    assert_narrow_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hi && !wide) |=> rsp_data == '0);

    // A response appears only after an accepted fetch (R10).
    assert_rsp_follows_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_lo || fetch_hi) |=> !rsp_valid);
endmodule

// File: tb/sim_stepmul_core.sv
// Bench for stepmul_core: a behavioural model, updated on each clock,
// is compared with the outputs at every falling edge.
module sim_stepmul_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_step = '0;
    logic [4:0]  cmd_dst = '0;
    logic [31:0] cmd_opa = '0, cmd_opb = '0;
    logic        rsp_valid, err_flag;
    logic [4:0]  rsp_dst;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    // Behavioural model state.
    bit              m_active = 0, m_wide = 0;
    int              m_done = 0;
    longint unsigned m_acc = 0, m_a = 0, m_b = 0;
    bit              e_err = 0, e_rv = 0;
    logic [31:0]     e_data = '0;
    logic [4:0]      e_dst = '0;
    string           cur_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    stepmul_core u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_step(cmd_step), .cmd_dst(cmd_dst), .cmd_opa(cmd_opa), .cmd_opb(cmd_opb),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_data(rsp_data), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_tag, "err_flag", longint'(err_flag), longint'(e_err));
        chk(cur_tag, "rsp_valid", longint'(rsp_valid), longint'(e_rv));
        if (e_rv && rsp_valid) begin
            chk(cur_tag, "rsp_data", longint'(rsp_data), longint'(e_data));
            chk(cur_tag, "rsp_dst", longint'(rsp_dst), longint'(e_dst));
        end
    endtask

    task automatic model(input bit v, input logic [1:0] op, input int st,
                         input logic [4:0] d, input longint unsigned a, input longint unsigned b);
        int need;
        need = m_wide ? 4 : 2;
        e_rv = 0;
        if (v) begin
            case (op)
                2'd0: if (st != 0) e_err = 1;
                      else begin
                          m_active = 1; m_wide = (a > 65535) || (b > 65535);
                          m_done = 0; m_acc = 0; m_a = a; m_b = b; e_err = 0;
                      end
                2'd1: if (m_active && st == m_done + 1 && st <= need) begin
                          m_acc += (m_a * ((m_b >> (8 * (st - 1))) & 64'hFF)) << (8 * (st - 1));
                          m_done++;
                      end else e_err = 1;
                default: if (m_active && m_done == need) begin
                          e_rv = 1; e_dst = d;
                          e_data = (op == 2'd3) ? m_acc[63:32] : m_acc[31:0];
                      end else e_err = 1;
            endcase
        end
    endtask

    task automatic issue(input bit v, input logic [1:0] op, input int st, input logic [4:0] d,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        compare();
        cmd_valid = v; cmd_op = op; cmd_step = 3'(st); cmd_dst = d;
        cmd_opa = a; cmd_opb = b; cur_tag = tag;
        @(posedge clk);
        model(v, op, st, d, {32'd0, a}, {32'd0, b});
    endtask

    // Full legal product: start, all steps, low and high fetch.
    task automatic product(input logic [31:0] a, input logic [31:0] b, input string tag);
        int n;
        n = (a > 32'hFFFF || b > 32'hFFFF) ? 4 : 2;
        issue(1, 2'd0, 0, 5'd0, a, b, tag);
        for (int i = 1; i <= n; i++) issue(1, 2'd1, i, 5'd0, 0, 0, tag);
        issue(1, 2'd2, 0, 5'd7, 0, 0, tag);
        issue(1, 2'd3, 0, 5'd9, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, then step and fetch with no open sequence
        issue(0, 2'd0, 0, 0, 0, 0, "R1");
        issue(1, 2'd1, 1, 0, 0, 0, "R1 R5 step before start");
        issue(1, 2'd2, 0, 0, 0, 0, "R1 R8 fetch before start");
        // R2 R4 R6 R7 narrow product; start clears error (R9)
        product(32'd1234, 32'd5678, "R2 R4 R6 R7 R9 narrow");
        product(32'hFFFF, 32'hFFFF, "R2 R7 narrow max");
        product(32'h10000, 32'd1, "R2 wide threshold");
        product(32'hDEADBEEF, 32'h12345678, "R4 R6 R7 wide");
        product(32'hFFFFFFFF, 32'hFFFFFFFF, "R4 wide max");
        // R5: out-of-order and zero step leave accumulator intact
        issue(1, 2'd0, 0, 0, 32'h89ABCDEF, 32'h01020304, "R2");
        issue(1, 2'd1, 2, 0, 0, 0, "R5 out of order");
        issue(1, 2'd1, 0, 0, 0, 0, "R5 zero index");
        issue(1, 2'd1, 1, 0, 0, 0, "R4 R9 sticky");
        issue(1, 2'd1, 1, 0, 0, 0, "R5 repeated step");
        issue(1, 2'd1, 2, 0, 0, 0, "R4");
        // R8 early fetch mid wide sequence; R3 bad start mid sequence
        issue(1, 2'd2, 0, 3, 0, 0, "R8 early low");
        issue(1, 2'd3, 0, 3, 0, 0, "R8 early high");
        issue(1, 2'd0, 3, 0, 32'h5, 32'h5, "R3 start with step");
        issue(1, 2'd1, 3, 0, 0, 0, "R3 R4");
        issue(1, 2'd1, 4, 0, 0, 0, "R4");
        issue(1, 2'd1, 5, 0, 0, 0, "R5 beyond count");
        issue(1, 2'd3, 0, 5'd31, 0, 0, "R3 R7 R9 high first");
        issue(1, 2'd2, 0, 5'd1, 0, 0, "R6 R9 repeat");
        issue(1, 2'd2, 0, 5'd2, 0, 0, "R9 repeat low");
        issue(0, 2'd2, 0, 0, 0, 0, "R10 idle");
        // R5: excess step in narrow mode
        issue(1, 2'd0, 0, 0, 32'd300, 32'd40000, "R2");
        issue(1, 2'd1, 1, 0, 0, 0, "R4");
        issue(1, 2'd1, 2, 0, 0, 0, "R4");
        issue(1, 2'd1, 3, 0, 0, 0, "R5 narrow excess");
        issue(1, 2'd2, 0, 4, 0, 0, "R6 after excess");
        issue(0, 2'd0, 0, 0, 0, 0, "R10 idle");
        // Random legal products, mixing narrow and wide operands
        for (int k = 0; k < 40; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (k % 2 == 0) begin ra = ra & 32'hFFFF; rb = rb & 32'hFFFF; end
            product(ra, rb, "R4 R6 R7 random");
        end
        // Random command stream exercising every ordering
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom;
            issue(r[0] | r[1], r[3:2], (r[4] ? 0 : int'(r[7:5] % 6)), r[12:8],
                  (r[13] ? $urandom : ($urandom & 32'hFFFF)),
                  (r[14] ? $urandom : ($urandom & 32'hFFFF)), "R3 R5 R8 R9 R10 random");
        end
        @(negedge clk);
        compare();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule